// File: doc/BRIEF.md
# Change-of-State Input Monitor with Snapshot Latch

This block watches a bank of digital inputs and raises one interrupt request whenever an armed input changes level, on either a rising or a falling transition. Every input first passes through a two-flop synchronizer. An input counts as changed when its newest synchronized sample differs from the sample one cycle earlier, and only if its enable bit is set.

At the moment of the event the block captures the synchronized levels of all inputs in a snapshot register. The request and the snapshot then hold until the host sends a clear pulse. The clear drops the request and zeroes the snapshot at the same edge. Events that arrive while a request is pending leave the snapshot as it is.

The host sees one register location. A write to that location loads the per-channel enable mask. A read from it returns the snapshot. Writes to any other address are ignored, and reads from any other address return zero.

Top module: `cos_irq_latch`

## Requirements
- R1: After reset, `irq` is 0, a read at offset 6 returns 0, and the enable mask is all zeros, so input changes raise no request until a channel is enabled.
- R2: A change on `din` that is stable before rising edge k first shows on `irq` after rising edge k+2. This is two synchronizer flops plus the request register. After edge k+1, `irq` is still 0.
- R3: A low-to-high transition on an enabled channel sets `irq`.
- R4: A high-to-low transition on an enabled channel sets `irq`.
- R5: A transition on a channel whose enable bit is 0 has no effect on `irq` or on the snapshot.
- R6: When the request is raised, the snapshot holds the synchronized level of every input. Bit x is channel x, and a 1 means high.
- R7: Once raised, `irq` stays 1 until `irq_clear` is sampled high. Further enabled transitions do not change the snapshot.
- R8: `irq_clear` sampled high with no enabled transition in that cycle makes `irq` 0 and the snapshot 0 at the same edge.
- R9: If an enabled transition and `irq_clear` occur in the same cycle, the event wins: `irq` stays 1 and the snapshot takes the new levels.
- R10: A write (`reg_wr`=1) at offset 6 loads `reg_wdata` into the enable mask, with bit x enabling channel x. A write at any other offset leaves the mask unchanged. A read at any other offset returns 0.
- R11: A mask write takes effect from the cycle after its write edge. A transition whose detection cycle ends at the write edge is judged by the old mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | ADDR_W (3) | Register offset for the read and write port |
| reg_wr | input | 1 | Write strobe, sampled on the rising edge |
| reg_wdata | input | NUM_CH (16) | Write data (enable mask) |
| reg_rdata | output | NUM_CH (16) | Read data: the snapshot at offset 6, zero elsewhere |
| din | input | NUM_CH (16) | Asynchronous digital inputs |
| irq_clear | input | 1 | Acknowledge pulse that clears the request and the snapshot |
| irq | output | 1 | Interrupt request, level |

## Verification
On every cycle the assertions check the following:
- a pending request that is not cleared persists (R7);
- the snapshot stays frozen while a request is pending;
- a clear without an event empties both the request and the snapshot (R8);
- any detected event leaves the request set (R3, R4, R9);
- the request never rises without a detected event;
- a write at a foreign offset leaves the mask untouched (R10).

Some behaviours need the bench's scenarios instead. These are the end-to-end latency through the synchronizer (R2), the exact snapshot contents against input levels (R6), and the effect of the mask on the channel the bench chose (R5). The mask-write race (R11) also belongs here. The bench sweeps every channel in both directions against an arithmetic model.

// File: rtl/cos_pkg.sv
// Package: default sizes shared by the change-of-state monitor.
// Assumes: users override through the top module parameters.
package cos_pkg;
    localparam int DEF_NUM_CH     = 16;
    localparam int DEF_ADDR_W     = 3;
    localparam int DEF_COS_OFFSET = 6;
    localparam int DEF_SYNC_DEPTH = 2;
endpackage

// File: rtl/cos_sync.sv
// Module: per-channel multi-flop synchronizer for asynchronous inputs.
// Assumes: DEPTH >= 2; each bit is treated as an independent signal.
module cos_sync #(
    parameter int NUM_CH = 16,
    parameter int DEPTH  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] d_async,
    output logic [NUM_CH-1:0] q_sync
);
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        logic [DEPTH-1:0] chain_q;
        // shift the input through DEPTH flops
        always_ff @(posedge clk) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[DEPTH-2:0], d_async[ch]};
        end
        assign q_sync[ch] = chain_q[DEPTH-1];
    end
endmodule

// File: rtl/cos_edge_detect.sv
// Module: finds level changes on synchronized inputs and gates them by the mask.
// Assumes: inputs are already synchronous; both edge directions count.
module cos_edge_detect #(
    parameter int NUM_CH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] level,
    input  logic [NUM_CH-1:0] enable,
    output logic              event_hit
);
    logic [NUM_CH-1:0] prev_q;
    logic [NUM_CH-1:0] changed;

    // remember last cycle's synchronized levels
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= level;
    end

    // a change in either direction on an armed channel is an event
    always_comb begin
        changed   = (level ^ prev_q) & enable;
        event_hit = |changed;
    end
endmodule

// File: rtl/cos_latch_ctrl.sv
// Module: holds the interrupt request and the input snapshot taken at the event.
// Assumes: clr is a synchronous pulse; an event in the clear cycle takes priority.
module cos_latch_ctrl #(
    parameter int NUM_CH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              event_hit,
    input  logic              clr,
    input  logic [NUM_CH-1:0] level,
    output logic              irq,
    output logic [NUM_CH-1:0] snapshot
);
    logic              irq_q;
    logic [NUM_CH-1:0] snap_q;

    // set on event when idle or clearing, drop on a plain clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q  <= 1'b0;
            snap_q <= '0;
        end else if (event_hit && (!irq_q || clr)) begin
            irq_q  <= 1'b1;
            snap_q <= level;
        end else if (clr) begin
            irq_q  <= 1'b0;
            snap_q <= '0;
        end
    end

    assign irq      = irq_q;
    assign snapshot = snap_q;

    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q && !clr |=> irq_q);                                   // R7
    AST_SNAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q && !clr |=> $stable(snap_q));                         // R7
    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clr && !event_hit |=> !irq_q && (snap_q == '0));            // R8
    AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        event_hit |=> irq_q);                                       // R9
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_q && !event_hit |=> !irq_q);                           // R5
endmodule

// File: rtl/cos_irq_latch.sv
// Module: top of the change-of-state monitor with one shared register offset.
// Assumes: writes at COS_OFFSET load the enable mask, reads there return the snapshot.
module cos_irq_latch
    import cos_pkg::*;
#(
    parameter int NUM_CH     = DEF_NUM_CH,
    parameter int ADDR_W     = DEF_ADDR_W,
    parameter int COS_OFFSET = DEF_COS_OFFSET,
    parameter int SYNC_DEPTH = DEF_SYNC_DEPTH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [NUM_CH-1:0] reg_wdata,
    output logic [NUM_CH-1:0] reg_rdata,
    input  logic [NUM_CH-1:0] din,
    input  logic              irq_clear,
    output logic              irq
);
    localparam logic [ADDR_W-1:0] SEL_ADDR = ADDR_W'(COS_OFFSET);

    logic [NUM_CH-1:0] mask_q;
    logic [NUM_CH-1:0] level_s;
    logic [NUM_CH-1:0] snap;
    logic              hit;
    logic              sel;

    assign sel = (reg_addr == SEL_ADDR);

    // enable mask register, loaded by writes at the shared offset
    always_ff @(posedge clk) begin
        if (!rst_n)            mask_q <= '0;
        else if (reg_wr && sel) mask_q <= reg_wdata;
    end

    // reads at the shared offset return the snapshot
    always_comb begin
        reg_rdata = sel ? snap : '0;
    end

    cos_sync #(.NUM_CH(NUM_CH), .DEPTH(SYNC_DEPTH)) sync_i (
        .clk(clk), .rst_n(rst_n), .d_async(din), .q_sync(level_s)
    );

    cos_edge_detect #(.NUM_CH(NUM_CH)) edge_i (
        .clk(clk), .rst_n(rst_n), .level(level_s), .enable(mask_q),
        .event_hit(hit)
    );

    cos_latch_ctrl #(.NUM_CH(NUM_CH)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .event_hit(hit), .clr(irq_clear),
        .level(level_s), .irq(irq), .snapshot(snap)
    );

    AST_FOREIGN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && !sel |=> $stable(mask_q));                        // R10
    AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && sel |=> mask_q == $past(reg_wdata));              // R10
endmodule

// File: tb/cos_irq_latch_tb_top.sv
module cos_irq_latch_tb_top;
    localparam int N = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    reg_addr = 3'd6;
    logic          reg_wr = 1'b0;
    logic [N-1:0]  reg_wdata = '0;
    logic [N-1:0]  reg_rdata;
    logic [N-1:0]  din = '0;
    logic          irq_clear = 1'b0;
    logic          irq;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    logic         exp_irq = 1'b0;
    logic [N-1:0] exp_snap = '0;
    logic [N-1:0] exp_mask = '0;

    always #10 clk = ~clk;

    cos_irq_latch dut_i (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .din(din),
        .irq_clear(irq_clear), .irq(irq)
    );

    task automatic check(input string tag, input logic [N-1:0] got, input logic [N-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic check_state(input string tag);
        check({tag, " irq"}, {{(N-1){1'b0}}, irq}, {{(N-1){1'b0}}, exp_irq});
        check({tag, " snap"}, reg_rdata, exp_snap);
    endtask

    task automatic write_reg(input logic [2:0] a, input logic [N-1:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 3'd6;
        if (a == 3'd6) exp_mask = d;
    endtask

    task automatic apply_din(input logic [N-1:0] v);
        logic [N-1:0] chg;
        chg = (din ^ v) & exp_mask;
        din = v;
        repeat (3) @(negedge clk);
        if (chg != '0 && !exp_irq) begin
            exp_irq = 1'b1;
            exp_snap = v;
        end
    endtask

    task automatic do_clear();
        irq_clear = 1'b1;
        @(negedge clk);
        irq_clear = 1'b0;
        exp_irq = 1'b0;
        exp_snap = '0;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_state("R1 reset");
        apply_din('1);
        check_state("R1 zero mask ignores change");
        apply_din('0);
        check_state("R1 zero mask ignores fall");

        // per-channel sweep in both directions
        for (int ch = 0; ch < N; ch++) begin
            logic [N-1:0] bit_m;
            bit_m = N'(1) << ch;
            write_reg(3'd6, bit_m);
            apply_din(din ^ ~bit_m);
            check_state("R5 disabled channels");
            apply_din(din ^ bit_m);
            check_state((din & bit_m) != 0 ? "R3 rise / R6 snapshot" : "R4 fall / R6 snapshot");
            write_reg(3'd6, '1);
            apply_din(din ^ (N'(ch * 37 + 5) | bit_m));
            check_state("R7 held snapshot");
            do_clear();
            check_state("R8 clear");
            apply_din(din ^ bit_m);
            check_state("R4 R3 second direction");
            do_clear();
            check_state("R8 clear again");
        end

        // R2: latency through the synchronizer
        write_reg(3'd6, '1);
        din = din ^ 16'h0001;
        @(negedge clk);
        @(negedge clk);
        check("R2 not yet", {{(N-1){1'b0}}, irq}, '0);
        @(negedge clk);
        check("R2 after third edge", {{(N-1){1'b0}}, irq}, 16'h1);
        exp_irq = 1'b1; exp_snap = din;
        check_state("R2 snapshot");

        // R9: event and clear in the same cycle
        din = din ^ 16'h8000;
        @(negedge clk);
        @(negedge clk);
        irq_clear = 1'b1;
        @(negedge clk);
        irq_clear = 1'b0;
        exp_irq = 1'b1; exp_snap = din;
        check_state("R9 event wins over clear");
        do_clear();
        check_state("R9 cleared after");

        // R10: foreign offset write and read
        write_reg(3'd2, '0);
        apply_din(din ^ 16'h0100);
        check_state("R10 foreign write ignored");
        reg_addr = 3'd3;
        #1;
        check("R10 foreign read zero", reg_rdata, '0);
        reg_addr = 3'd6;
        do_clear();
        write_reg(3'd6, '0);

        // R11: write lands at the end of the detection cycle -> old mask
        din = din ^ 16'h0010;
        @(negedge clk);
        @(negedge clk);
        write_reg(3'd6, 16'h0010);
        @(negedge clk);
        check_state("R11 late write uses old mask");
        // R11: write one cycle earlier -> new mask
        write_reg(3'd6, '0);
        din = din ^ 16'h0020;
        @(negedge clk);
        write_reg(3'd6, 16'h0020);
        @(negedge clk);
        exp_irq = 1'b1; exp_snap = din;
        check_state("R11 early write uses new mask");
        do_clear();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule